// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits at the instruction boundary of a processor core. On each cycle where the core signals a boundary, it looks at a pending synchronous exception and a pending external interrupt. It picks at most one of them and performs the processor state switch for it in a single registered update. The interrupt request it receives has already been filtered against the current interrupt mask level. The block only latches the values handed to it. The interrupt controller, the instruction decoder and the register file stay outside.

On entry it saves three values: the status word, the program counter and the stack register. It then computes a new status word and a new program counter from the event class and the vector base, and records the event code in the exception or interrupt event register. It emits a one-cycle `taken` pulse, along with pulses that tell the core to drop its delay-slot and sleep state.

A second exception that arrives while the block bit is set cannot be serviced. It is turned into a reset request instead.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both pending at one boundary, the exception is taken. `expevt_o` gets its code, `intevt_o` keeps its old value, and the new PC is an exception vector.
- R2: If status bit 28 (block bit) is set and an exception with a code other than 0x1E0 is pending, then `reset_req_o` pulses for one cycle after the boundary. `taken_o` stays low and every saved and new-state register keeps its value.
- R3: An exception with code 0x1E0 is taken even while the block bit is set, and it vectors to base + 0x100.
- R4: While the block bit is set, an interrupt alone is ignored (no pulse, registers unchanged) unless `sleep_i` is high. When `sleep_i` is high, the interrupt is taken and `sleep_clr_o` pulses.
- R5: On entry, `ssr_o` gets the status input, `spc_o` gets the PC and `sgr_o` gets R15. `sr_new_o` is the status input with bits 28, 29 and 30 set.
- R6: An event taken with `dslot_i` high saves PC − 2 and pulses `dslot_clr_o`.
- R7: Codes 0x000, 0x020 and 0x140 have three effects. They clear status bit 15, set status bits 7:4 to 0xF, and load the new PC with 0xA0000000.
- R8: Codes 0x040 and 0x060 load the new PC with base + 0x400. Every other exception code that is not reset-class loads base + 0x100.
- R9: Code 0x160 saves PC + 2, combined with any delay-slot adjustment.
- R10: A taken interrupt writes its vector into `intevt_o`, loads base + 0x600 and leaves `expevt_o` unchanged.
- R11: An interrupt is not accepted while `dslot_i` is high.
- R12: Inputs are evaluated only on cycles with `step_i` high. `taken_o` pulses for exactly one cycle, in the cycle after the boundary, and all registers hold their value otherwise.
- R13: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction boundary strobe |
| exc_valid_i | input | 1 | Synchronous exception pending |
| exc_code_i | input | CODE_W | Exception code |
| irq_req_i | input | 1 | Filtered interrupt request |
| irq_vec_i | input | CODE_W | Interrupt vector code |
| sr_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| r15_i | input | XLEN | Current stack register |
| vbr_i | input | XLEN | Vector base |
| dslot_i | input | 1 | Core is in a delay slot |
| sleep_i | input | 1 | Core is sleeping |
| taken_o | output | 1 | One-cycle pulse: state switch performed |
| reset_req_o | output | 1 | One-cycle pulse: reset request |
| dslot_clr_o | output | 1 | One-cycle pulse: clear delay-slot flag |
| sleep_clr_o | output | 1 | One-cycle pulse: leave sleep |
| ssr_o | output | XLEN | Saved status |
| spc_o | output | XLEN | Saved PC |
| sgr_o | output | XLEN | Saved R15 |
| sr_new_o | output | XLEN | New status word |
| pc_new_o | output | XLEN | New program counter |
| expevt_o | output | CODE_W | Exception event register |
| intevt_o | output | CODE_W | Interrupt event register |

## Verification
The bench targets the case where an exception and an interrupt arrive together. A design with the wrong priority would write `intevt_o` and vector to base + 0x600. It also covers code 0x1E0 under the block bit, where a design that escalates every masked exception would raise a reset request instead of vectoring. A trap taken in a delay slot must leave the saved PC equal to the input, so a design that applies only one of the two adjustments shows up as off by two. Further cases cover interrupts under the block bit with and without sleep, and interrupts during a delay slot. A design that honours either wrongly would pulse `taken_o` when it should stay silent, or stay silent when it should pulse.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // status word bit positions (decoded by the core)
  localparam int SR_BL_BIT    = 28;
  localparam int SR_RB_BIT    = 29;
  localparam int SR_MD_BIT    = 30;
  localparam int SR_FD_BIT    = 15;
  localparam int SR_IMASK_LO  = 4;
  localparam int SR_IMASK_W   = 4;

  // event codes with special handling
  localparam int CODE_NMI_OK  = 'h1E0;
  localparam int CODE_TRAP    = 'h160;
  localparam int N_RST_CODES  = 3;
  localparam int N_TLB_CODES  = 2;

  typedef int code_list_rst_t [N_RST_CODES];
  typedef int code_list_tlb_t [N_TLB_CODES];

  localparam code_list_rst_t RST_CODES = '{'h000, 'h020, 'h140};
  localparam code_list_tlb_t TLB_CODES = '{'h040, 'h060};

  typedef enum logic [1:0] {
    VC_GENERAL = 2'd0,
    VC_RESET   = 2'd1,
    VC_TLB     = 2'd2,
    VC_IRQ     = 2'd3
  } vec_class_e;

endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              step_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              bl_i,
  input  logic              dslot_i,
  input  logic              sleep_i,
  output logic              take_o,
  output logic              take_exc_o,
  output logic              rst_req_o
);

  logic want_exc;
  logic want_irq;
  logic exc_escalates;
  logic irq_masked;

  always_comb begin
    want_exc      = step_i && exc_valid_i;
    want_irq      = step_i && irq_req_i && !exc_valid_i && !dslot_i;
    exc_escalates = want_exc && bl_i && (exc_code_i != CODE_W'(CODE_NMI_OK));
    irq_masked    = want_irq && bl_i && !sleep_i;

    rst_req_o  = exc_escalates;
    take_exc_o = want_exc && !exc_escalates;
    take_o     = take_exc_o || (want_irq && !irq_masked);
  end

endmodule

// File: rtl/exc_entry_vec.sv
module exc_entry_vec
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter logic [31:0] OFS_GEN  = 32'h100,
  parameter logic [31:0] OFS_TLB  = 32'h400,
  parameter logic [31:0] OFS_IRQ  = 32'h600,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter int          PC_STEP  = 2
) (
  input  logic              take_exc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              dslot_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o
);

  localparam logic [XLEN-1:0] STEP_X = XLEN'(PC_STEP);

  logic [N_RST_CODES-1:0] rst_hit;
  logic [N_TLB_CODES-1:0] tlb_hit;
  vec_class_e             vclass;
  logic                   is_trap;

  for (genvar g = 0; g < N_RST_CODES; g++) begin : g_rst
    assign rst_hit[g] = (exc_code_i == CODE_W'(RST_CODES[g]));
  end

  for (genvar g = 0; g < N_TLB_CODES; g++) begin : g_tlb
    assign tlb_hit[g] = (exc_code_i == CODE_W'(TLB_CODES[g]));
  end

  always_comb begin
    if (!take_exc_i)   vclass = VC_IRQ;
    else if (|rst_hit) vclass = VC_RESET;
    else if (|tlb_hit) vclass = VC_TLB;
    else               vclass = VC_GENERAL;
    is_trap = take_exc_i && (exc_code_i == CODE_W'(CODE_TRAP));
  end

  // saved PC: delay-slot rollback and trap advance are independent
  always_comb begin
    spc_o = pc_i;
    if (dslot_i) spc_o = spc_o - STEP_X;
    if (is_trap) spc_o = spc_o + STEP_X;
  end

  always_comb begin
    sr_o = sr_i;
    sr_o[SR_BL_BIT] = 1'b1;
    sr_o[SR_MD_BIT] = 1'b1;
    sr_o[SR_RB_BIT] = 1'b1;
    pc_o = vbr_i + XLEN'(OFS_GEN);
    unique case (vclass)
      VC_RESET: begin
        sr_o[SR_FD_BIT] = 1'b0;
        sr_o[SR_IMASK_LO +: SR_IMASK_W] = '1;
        pc_o = XLEN'(RESET_PC);
      end
      VC_TLB:  pc_o = vbr_i + XLEN'(OFS_TLB);
      VC_IRQ:  pc_o = vbr_i + XLEN'(OFS_IRQ);
      default: pc_o = vbr_i + XLEN'(OFS_GEN);
    endcase
  end

endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              take_exc_i,
  input  logic              rst_req_i,
  input  logic              dslot_i,
  input  logic              sleep_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   spc_nxt_i,
  input  logic [XLEN-1:0]   sr_nxt_i,
  input  logic [XLEN-1:0]   pc_nxt_i,
  output logic              taken_o,
  output logic              reset_req_o,
  output logic              dslot_clr_o,
  output logic              sleep_clr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   sr_new_o,
  output logic [XLEN-1:0]   pc_new_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);

  logic              save_en;
  logic              exp_en;
  logic              int_en;
  logic              taken_d, rreq_d, dclr_d, sclr_d;

  always_comb begin
    save_en = take_i;
    exp_en  = take_i && take_exc_i;
    int_en  = take_i && !take_exc_i;
    taken_d = take_i;
    rreq_d  = rst_req_i;
    dclr_d  = take_i && dslot_i;
    sclr_d  = take_i && sleep_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o     <= 1'b0;
      reset_req_o <= 1'b0;
      dslot_clr_o <= 1'b0;
      sleep_clr_o <= 1'b0;
    end else begin
      taken_o     <= taken_d;
      reset_req_o <= rreq_d;
      dslot_clr_o <= dclr_d;
      sleep_clr_o <= sclr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      sr_new_o <= '0;
      pc_new_o <= '0;
    end else if (save_en) begin
      ssr_o    <= sr_i;
      spc_o    <= spc_nxt_i;
      sgr_o    <= r15_i;
      sr_new_o <= sr_nxt_i;
      pc_new_o <= pc_nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expevt_o <= '0;
    end else if (exp_en) begin
      expevt_o <= exc_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intevt_o <= '0;
    end else if (int_en) begin
      intevt_o <= irq_vec_i;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter logic [31:0] OFS_GEN  = 32'h100,
  parameter logic [31:0] OFS_TLB  = 32'h400,
  parameter logic [31:0] OFS_IRQ  = 32'h600,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter int          PC_STEP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  input  logic              sleep_i,
  output logic              taken_o,
  output logic              reset_req_o,
  output logic              dslot_clr_o,
  output logic              sleep_clr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   sr_new_o,
  output logic [XLEN-1:0]   pc_new_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);

  logic            take;
  logic            take_exc;
  logic            rst_req;
  logic [XLEN-1:0] spc_nxt;
  logic [XLEN-1:0] sr_nxt;
  logic [XLEN-1:0] pc_nxt;

  exc_entry_arb #(.CODE_W(CODE_W)) u_arb (
    .step_i      (step_i),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .irq_req_i   (irq_req_i),
    .bl_i        (sr_i[SR_BL_BIT]),
    .dslot_i     (dslot_i),
    .sleep_i     (sleep_i),
    .take_o      (take),
    .take_exc_o  (take_exc),
    .rst_req_o   (rst_req)
  );

  exc_entry_vec #(
    .XLEN(XLEN), .CODE_W(CODE_W), .OFS_GEN(OFS_GEN), .OFS_TLB(OFS_TLB),
    .OFS_IRQ(OFS_IRQ), .RESET_PC(RESET_PC), .PC_STEP(PC_STEP)
  ) u_vec (
    .take_exc_i (take_exc),
    .exc_code_i (exc_code_i),
    .dslot_i    (dslot_i),
    .sr_i       (sr_i),
    .pc_i       (pc_i),
    .vbr_i      (vbr_i),
    .spc_o      (spc_nxt),
    .sr_o       (sr_nxt),
    .pc_o       (pc_nxt)
  );

  exc_entry_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .take_exc_i  (take_exc),
    .rst_req_i   (rst_req),
    .dslot_i     (dslot_i),
    .sleep_i     (sleep_i),
    .exc_code_i  (exc_code_i),
    .irq_vec_i   (irq_vec_i),
    .sr_i        (sr_i),
    .r15_i       (r15_i),
    .spc_nxt_i   (spc_nxt),
    .sr_nxt_i    (sr_nxt),
    .pc_nxt_i    (pc_nxt),
    .taken_o     (taken_o),
    .reset_req_o (reset_req_o),
    .dslot_clr_o (dslot_clr_o),
    .sleep_clr_o (sleep_clr_o),
    .ssr_o       (ssr_o),
    .spc_o       (spc_o),
    .sgr_o       (sgr_o),
    .sr_new_o    (sr_new_o),
    .pc_new_o    (pc_new_o),
    .expevt_o    (expevt_o),
    .intevt_o    (intevt_o)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic              exc_valid_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic              irq_req_i,
  input logic [XLEN-1:0]   sr_i,
  input logic              dslot_i,
  input logic              taken_o,
  input logic              reset_req_o,
  input logic [XLEN-1:0]   ssr_o,
  input logic [XLEN-1:0]   spc_o,
  input logic [XLEN-1:0]   pc_new_o,
  input logic [XLEN-1:0]   sr_new_o,
  input logic [CODE_W-1:0] expevt_o
);

  // R2
  bl_escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && exc_valid_i && sr_i[28] && exc_code_i != CODE_W'('h1E0))
      |=> (reset_req_o && !taken_o));

  // R2
  rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req_o && taken_o));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> ($stable(ssr_o) && $stable(spc_o) && $stable(pc_new_o)));

  // R5
  sr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (sr_new_o[28] && sr_new_o[29] && sr_new_o[30]));

  // R11
  dslot_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !exc_valid_i && irq_req_i && dslot_i) |=> !taken_o);

  // R1
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && exc_valid_i && irq_req_i && !sr_i[28])
      |=> (taken_o && expevt_o == $past(exc_code_i)));

  // R7
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && exc_valid_i && !sr_i[28] && exc_code_i == CODE_W'('h020))
      |=> (pc_new_o == XLEN'(32'hA000_0000) && sr_new_o[7:4] == 4'hF));

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_i      (step_i),
  .exc_valid_i (exc_valid_i),
  .exc_code_i  (exc_code_i),
  .irq_req_i   (irq_req_i),
  .sr_i        (sr_i),
  .dslot_i     (dslot_i),
  .taken_o     (taken_o),
  .reset_req_o (reset_req_o),
  .ssr_o       (ssr_o),
  .spc_o       (spc_o),
  .pc_new_o    (pc_new_o),
  .sr_new_o    (sr_new_o),
  .expevt_o    (expevt_o)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, exc_valid_i, irq_req_i, dslot_i, sleep_i;
  logic [11:0] exc_code_i, irq_vec_i;
  logic [31:0] sr_i, pc_i, r15_i, vbr_i;
  logic        taken_o, reset_req_o, dslot_clr_o, sleep_clr_o;
  logic [31:0] ssr_o, spc_o, sgr_o, sr_new_o, pc_new_o;
  logic [11:0] expevt_o, intevt_o;

  int checks = 0;
  int errors = 0;

  // expected state
  logic        e_tk, e_rr, e_dc, e_sc;
  logic [31:0] e_ssr, e_spc, e_sgr, e_sr, e_pc;
  logic [11:0] e_exp, e_int;
  string       t_spc, t_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .exc_valid_i(exc_valid_i),
    .exc_code_i(exc_code_i), .irq_req_i(irq_req_i), .irq_vec_i(irq_vec_i),
    .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i), .vbr_i(vbr_i),
    .dslot_i(dslot_i), .sleep_i(sleep_i), .taken_o(taken_o),
    .reset_req_o(reset_req_o), .dslot_clr_o(dslot_clr_o),
    .sleep_clr_o(sleep_clr_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o),
    .sr_new_o(sr_new_o), .pc_new_o(pc_new_o), .expevt_o(expevt_o),
    .intevt_o(intevt_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pick_code(int k);
    case (k % 10)
      0: return 12'h000;  1: return 12'h020;  2: return 12'h140;
      3: return 12'h040;  4: return 12'h060;  5: return 12'h160;
      6: return 12'h1E0;  7: return 12'h0E0;  8: return 12'h180;
      default: return 12'h100;
    endcase
  endfunction

  // reference model, written from the requirements
  task automatic model();
    logic bl, dexc, dirq, rstc;
    bl   = sr_i[28];
    dexc = step_i && exc_valid_i;
    dirq = step_i && irq_req_i && !exc_valid_i && !dslot_i;   // R11
    e_tk = 1'b0; e_rr = 1'b0; e_dc = 1'b0; e_sc = 1'b0;
    t_spc = "R5"; t_pc = "R8";
    if (bl && dexc && exc_code_i != 12'h1E0) e_rr = 1'b1;      // R2
    else if (bl && dirq && !sleep_i) e_tk = 1'b0;              // R4
    else if (dexc || dirq) begin
      e_tk  = 1'b1;
      e_dc  = dslot_i;
      e_sc  = sleep_i;
      e_ssr = sr_i; e_sgr = r15_i;
      e_spc = pc_i;
      if (dslot_i) begin e_spc = e_spc - 2; t_spc = "R6"; end
      if (dexc && exc_code_i == 12'h160) begin e_spc = e_spc + 2; t_spc = "R9"; end
      e_sr = sr_i | 32'h7000_0000;
      rstc = dexc && (exc_code_i == 12'h000 || exc_code_i == 12'h020 ||
                      exc_code_i == 12'h140);
      if (dexc) begin
        e_exp = exc_code_i;
        if (rstc) begin
          e_sr[15] = 1'b0; e_sr[7:4] = 4'hF; e_pc = 32'hA000_0000; t_pc = "R7";
        end else if (exc_code_i == 12'h040 || exc_code_i == 12'h060)
          e_pc = vbr_i + 32'h400;
        else
          e_pc = vbr_i + 32'h100;
      end else begin
        e_int = irq_vec_i; e_pc = vbr_i + 32'h600; t_pc = "R10";
      end
    end
  endtask

  task automatic compare_all();
    chk("R12 taken", {31'd0, taken_o}, {31'd0, e_tk});
    chk("R2 reset_req", {31'd0, reset_req_o}, {31'd0, e_rr});
    chk("R6 dslot_clr", {31'd0, dslot_clr_o}, {31'd0, e_dc});
    chk("R4 sleep_clr", {31'd0, sleep_clr_o}, {31'd0, e_sc});
    chk("R5 ssr", ssr_o, e_ssr);
    chk("R5 sgr", sgr_o, e_sgr);
    chk({t_spc, " spc"}, spc_o, e_spc);
    chk({t_pc, " sr_new"}, sr_new_o, e_sr);
    chk({t_pc, " pc_new"}, pc_new_o, e_pc);
    chk("R1 expevt", {20'd0, expevt_o}, {20'd0, e_exp});
    chk("R10 intevt", {20'd0, intevt_o}, {20'd0, e_int});
  endtask

  // drive one cycle at negedge, check after the next posedge
  task automatic cyc(logic st, logic ev, logic [11:0] code, logic iq,
                     logic [11:0] vec, logic [31:0] sr, logic dsl, logic slp);
    step_i = st; exc_valid_i = ev; exc_code_i = code; irq_req_i = iq;
    irq_vec_i = vec; sr_i = sr; dslot_i = dsl; sleep_i = slp;
    pc_i = $urandom; r15_i = $urandom; vbr_i = $urandom & 32'hFFFF_F000;
    model();
    @(negedge clk);
    compare_all();
    step_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    step_i = 0; exc_valid_i = 0; exc_code_i = 0; irq_req_i = 0; irq_vec_i = 0;
    sr_i = 0; pc_i = 0; r15_i = 0; vbr_i = 0; dslot_i = 0; sleep_i = 0;
    e_ssr = 0; e_spc = 0; e_sgr = 0; e_sr = 0; e_pc = 0; e_exp = 0; e_int = 0;
    e_tk = 0; e_rr = 0; e_dc = 0; e_sc = 0; t_spc = "R13"; t_pc = "R13";
    repeat (3) @(negedge clk);
    // R13 reset state
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);

    // R1 exception wins over interrupt
    cyc(1, 1, 12'h180, 1, 12'h3C0, 32'h0000_00F0, 0, 0);
    // R10 plain interrupt
    cyc(1, 0, 12'h000, 1, 12'h2A0, 32'h0000_0010, 0, 0);
    // R3 code 0x1E0 with block bit set
    cyc(1, 1, 12'h1E0, 0, 12'h000, 32'h1000_0000, 0, 0);
    // R2 masked exception escalates
    cyc(1, 1, 12'h0E0, 0, 12'h000, 32'h1000_0000, 0, 0);
    // R4 masked interrupt ignored when awake, taken when asleep
    cyc(1, 0, 12'h000, 1, 12'h500, 32'h1000_0000, 0, 0);
    cyc(1, 0, 12'h000, 1, 12'h520, 32'h1000_0000, 0, 1);
    // R11 interrupt in delay slot
    cyc(1, 0, 12'h000, 1, 12'h540, 32'h0, 1, 0);
    // R9 and R6 trap in delay slot
    cyc(1, 1, 12'h160, 0, 12'h000, 32'h0, 1, 0);
    // R7 reset-class clears FD
    cyc(1, 1, 12'h020, 0, 12'h000, 32'h0000_8000, 0, 0);
    // R8 TLB miss on write
    cyc(1, 1, 12'h060, 0, 12'h000, 32'h0, 0, 0);
    // R12 no boundary: nothing happens
    cyc(0, 1, 12'h100, 1, 12'h600, 32'h0, 0, 0);

    for (int i = 0; i < 800; i++) begin
      logic [31:0] s;
      s = $urandom;
      s[28] = ($urandom % 4 == 0);
      cyc(($urandom % 8) != 0, ($urandom % 2) == 0, pick_code($urandom),
          ($urandom % 2) == 0, 12'($urandom), s,
          ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule